// File: doc/BRIEF.md
# Low-Frequency FSK Tag Frame Demodulator

This block recovers the identifier frame sent by a low-frequency transponder that signals each bit with one of two carrier tones. Its input is a one-bit comparator level, qualified by a sample strobe (nominally 2 MHz). It counts low-to-high transitions of that level. Every sixteen of them it reads how many samples the group took, and it turns that count into a data bit, a zero bit, or a reject. Bits slide into a 128-bit window. When the window holds a complete frame, whose preamble and closing byte agree, the block latches the identifier, the check field and two tag flags, and pulses a completion strobe.

Control is a three-state machine. SYNC waits for the first rising transition and takes it as the reference point for span counting. HUNT measures spans, classifies them and shifts bits. HOLD freezes the results and ignores the input. Reset enters SYNC. SYNC moves to HUNT on the first rising transition. HUNT moves to HOLD when a frame is accepted. A restart pulse returns any state to SYNC. Computing the check value over the data, and the analog path, are left to the surrounding logic.

Top module: `lf_fsk_demod`

## Requirements
- R1: A rising transition is a strobed sample with `din`=1 whose previous strobed sample was 0. The span of a bit is the number of strobed samples after the previous measuring transition, up to and including the sixteenth rising transition after it. The transition that moves SYNC to HUNT is the first measuring point.
- R2: With nominal spans LO=(SAMPLE_HZ*16)/LO_HZ and HI=(SAMPLE_HZ*16)/HI_HZ and tolerance T=(LO-HI+1)/2, all with integer division, a span strictly between LO-T and LO+T is a 1. Otherwise, a span strictly between HI-T and HI+T is a 0. The defaults give LO=259, HI=238 and T=11.
- R3: A span outside both windows empties the whole 128-bit window, so a frame in progress is lost.
- R4: Bits arrive least significant first. Each new bit enters window bit 127 while the window shifts right.
- R5: A frame is accepted only when window bits [22:0] equal 23'h7E0000 and window bits [23:16] equal window bits [103:96]. A mismatch in either produces no strobe.
- R6: On acceptance, `id_data` takes window bits [87:24], `id_check` takes window bits [103:88], and `rewritable` takes window bit 111.
- R7: `ident_ok` is 1 only for a rewritable frame whose window bits [126:112] equal `id_data[14:0]`. Window bit 127 and `id_data[15]` play no part.
- R8: The span counter saturates at its all-ones value and never wraps. An overlong gap is therefore always rejected.
- R9: `done` is a single-cycle pulse. It goes high at the second rising clock edge after the edge that samples the measuring transition ending the frame's last bit.
- R10: In HOLD the outputs keep their values, no further `done` occurs, and `din` has no effect.
- R11: `restart` clears all outputs and the window and returns to SYNC. A complete frame sent afterwards is accepted.
- R12: After reset all outputs are zero and the block is in SYNC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| smp_en | input | 1 | Sample strobe qualifying `din` |
| din | input | 1 | Thresholded antenna level |
| restart | input | 1 | Leave HOLD (or any state) and rearm in SYNC |
| done | output | 1 | One-cycle pulse on frame acceptance |
| id_data | output | 64 | Latched identifier |
| id_check | output | 16 | Latched check field |
| rewritable | output | 1 | Latched rewritable-tag flag |
| ident_ok | output | 1 | Rewritable tag whose 15-bit ident copy matches the data |

## Verification
The assertions check the following on every cycle. `done` lasts one cycle and only leaves HUNT. The outputs are frozen in HOLD. `restart` clears the outputs. A rejected span empties the window. The span counter leaves its ceiling only by a clear. `ident_ok` never appears without `rewritable`. Only the bench's scenarios can show the exact sample counting at the window edges, the bit order and field positions, the preamble and closing-byte matching, the ident comparison, and the strobe timing; it drives whole frames with chosen spans, including the in-window sweep, out-of-window spans and a gap long enough to wrap a non-saturating counter.

// File: rtl/lf_fsk_pkg.sv
package lf_fsk_pkg;

    // Frame window geometry; positions are fixed by the frame format.
    localparam int FRAME_W   = 128;
    localparam int SOF_W     = 23;
    localparam logic [SOF_W-1:0] SOF_PAT = 23'h7E0000;
    localparam int START_LSB = 16;
    localparam int END_LSB   = 96;
    localparam int DATA_LSB  = 24;
    localparam int DATA_W    = 64;
    localparam int CHK_LSB   = 88;
    localparam int CHK_W     = 16;
    localparam int RW_BIT    = 111;
    localparam int IDENT_LSB = 112;
    localparam int IDENT_W   = 15;

    typedef enum logic [1:0] {
        ST_SYNC = 2'd0,
        ST_HUNT = 2'd1,
        ST_HOLD = 2'd2
    } dmod_state_e;

    typedef struct packed {
        logic one;
        logic zero;
        logic bad;
    } tone_sym_t;

    // Samples spanned by a group of carrier cycles at a given tone.
    function automatic int tone_span(input int fs, input int cyc, input int f);
        return (fs * cyc) / f;
    endfunction

endpackage

// File: rtl/lf_fsk_cycle_meter.sv
module lf_fsk_cycle_meter #(
    parameter int CYC_PER_BIT = 16,
    parameter int SPAN_W      = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_en,
    input  logic              din,
    input  logic              zero,
    input  logic              run,
    output logic              rise_o,
    output logic              meas_vld_o,
    output logic [SPAN_W-1:0] meas_span_o,
    output logic [SPAN_W-1:0] span_o
);

    localparam int CYC_W = (CYC_PER_BIT > 1) ? $clog2(CYC_PER_BIT) : 1;
    localparam logic [CYC_W-1:0]  CYC_LAST = CYC_W'(CYC_PER_BIT - 1);
    localparam logic [SPAN_W-1:0] SPAN_MAX = '1;

    logic              prev_q;
    logic [CYC_W-1:0]  cyc_q;
    logic [SPAN_W-1:0] span_q;
    logic [SPAN_W-1:0] span_inc;
    logic              rise;
    logic              close;

    assign rise     = smp_en & din & ~prev_q;
    assign span_inc = (span_q == SPAN_MAX) ? SPAN_MAX : span_q + 1'b1;
    assign close    = run & rise & (cyc_q == CYC_LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q      <= 1'b1;
            cyc_q       <= '0;
            span_q      <= '0;
            meas_vld_o  <= 1'b0;
            meas_span_o <= '0;
        end else begin
            meas_vld_o <= close & ~zero;
            if (close) begin
                meas_span_o <= span_inc;
            end
            if (smp_en) begin
                prev_q <= din;
            end
            if (zero) begin
                cyc_q  <= '0;
                span_q <= '0;
            end else if (run && smp_en) begin
                if (close) begin
                    cyc_q  <= '0;
                    span_q <= '0;
                end else begin
                    span_q <= span_inc;
                    if (rise) begin
                        cyc_q <= cyc_q + 1'b1;
                    end
                end
            end
        end
    end

    assign rise_o = rise;
    assign span_o = span_q;

endmodule

// File: rtl/lf_fsk_tone_classifier.sv
module lf_fsk_tone_classifier
    import lf_fsk_pkg::*;
#(
    parameter int SPAN_W  = 9,
    parameter int LO_SPAN = 259,
    parameter int HI_SPAN = 238,
    parameter int TOL     = 11
) (
    input  logic [SPAN_W-1:0] span,
    output tone_sym_t         sym
);

    localparam int ONE_MIN  = LO_SPAN - TOL;
    localparam int ONE_MAX  = LO_SPAN + TOL;
    localparam int ZERO_MIN = HI_SPAN - TOL;
    localparam int ZERO_MAX = HI_SPAN + TOL;

    int n;

    always_comb begin
        n        = int'(span);
        sym.one  = (n > ONE_MIN) && (n < ONE_MAX);
        sym.zero = !sym.one && (n > ZERO_MIN) && (n < ZERO_MAX);
        sym.bad  = !sym.one && !sym.zero;
    end

endmodule

// File: rtl/lf_fsk_frame_window.sv
module lf_fsk_frame_window
    import lf_fsk_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic               shift_en,
    input  logic               bit_in,
    input  logic               drop,
    output logic [FRAME_W-1:0] sreg_o,
    output logic               hit_o
);

    logic [FRAME_W-1:0] sreg_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sreg_q <= '0;
        end else if (clr) begin
            sreg_q <= '0;
        end else if (shift_en) begin
            if (drop) begin
                sreg_q <= '0;
            end else begin
                sreg_q <= {bit_in, sreg_q[FRAME_W-1:1]};
            end
        end
    end

    assign hit_o  = (sreg_q[SOF_W-1:0] == SOF_PAT) &&
                    (sreg_q[START_LSB +: 8] == sreg_q[END_LSB +: 8]);
    assign sreg_o = sreg_q;

endmodule

// File: rtl/lf_fsk_demod.sv
module lf_fsk_demod
    import lf_fsk_pkg::*;
#(
    parameter int SAMPLE_HZ   = 2_000_000,
    parameter int LO_HZ       = 123_200,
    parameter int HI_HZ       = 134_200,
    parameter int CYC_PER_BIT = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_en,
    input  logic              din,
    input  logic              restart,
    output logic              done,
    output logic [DATA_W-1:0] id_data,
    output logic [CHK_W-1:0]  id_check,
    output logic              rewritable,
    output logic              ident_ok
);

    localparam int LO_SPAN = tone_span(SAMPLE_HZ, CYC_PER_BIT, LO_HZ);
    localparam int HI_SPAN = tone_span(SAMPLE_HZ, CYC_PER_BIT, HI_HZ);
    localparam int TOL     = (LO_SPAN - HI_SPAN + 1) / 2;
    localparam int SPAN_W  = $clog2(LO_SPAN + TOL + 1);

    dmod_state_e        state_q;
    dmod_state_e        state_d;
    logic               rise;
    logic               meas_vld;
    logic [SPAN_W-1:0]  meas_span;
    logic [SPAN_W-1:0]  span_now;
    tone_sym_t          sym;
    logic               meas_bad;
    logic [FRAME_W-1:0] sreg;
    logic               hit;
    logic               in_hunt;

    assign in_hunt  = (state_q == ST_HUNT);
    assign meas_bad = sym.bad;

    lf_fsk_cycle_meter #(
        .CYC_PER_BIT (CYC_PER_BIT),
        .SPAN_W      (SPAN_W)
    ) u_meter (
        .clk         (clk),
        .rst_n       (rst_n),
        .smp_en      (smp_en),
        .din         (din),
        .zero        (restart | ~in_hunt),
        .run         (in_hunt),
        .rise_o      (rise),
        .meas_vld_o  (meas_vld),
        .meas_span_o (meas_span),
        .span_o      (span_now)
    );

    lf_fsk_tone_classifier #(
        .SPAN_W  (SPAN_W),
        .LO_SPAN (LO_SPAN),
        .HI_SPAN (HI_SPAN),
        .TOL     (TOL)
    ) u_class (
        .span (meas_span),
        .sym  (sym)
    );

    lf_fsk_frame_window u_window (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (restart | (state_q == ST_SYNC)),
        .shift_en (meas_vld & in_hunt),
        .bit_in   (sym.one),
        .drop     (~(sym.one | sym.zero)),
        .sreg_o   (sreg),
        .hit_o    (hit)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_SYNC;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_SYNC: if (rise) state_d = ST_HUNT;
            ST_HUNT: if (hit)  state_d = ST_HOLD;
            ST_HOLD: state_d = ST_HOLD;
            default: state_d = ST_SYNC;
        endcase
        if (restart) begin
            state_d = ST_SYNC;
        end
    end

    // Output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done       <= 1'b0;
            id_data    <= '0;
            id_check   <= '0;
            rewritable <= 1'b0;
            ident_ok   <= 1'b0;
        end else if (restart) begin
            done       <= 1'b0;
            id_data    <= '0;
            id_check   <= '0;
            rewritable <= 1'b0;
            ident_ok   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (in_hunt && hit) begin
                done       <= 1'b1;
                id_data    <= sreg[DATA_LSB +: DATA_W];
                id_check   <= sreg[CHK_LSB +: CHK_W];
                rewritable <= sreg[RW_BIT];
                ident_ok   <= sreg[RW_BIT] &&
                              (sreg[IDENT_LSB +: IDENT_W] == sreg[DATA_LSB +: IDENT_W]);
            end
        end
    end

endmodule

// File: rtl/lf_fsk_demod_chk.sv
module lf_fsk_demod_chk
    import lf_fsk_pkg::*;
#(
    parameter int SPAN_W = 9
) (
    input logic               clk,
    input logic               rst_n,
    input logic               restart,
    input logic               done,
    input logic [DATA_W-1:0]  id_data,
    input logic [CHK_W-1:0]   id_check,
    input logic               rewritable,
    input logic               ident_ok,
    input dmod_state_e        state,
    input logic               meas_vld,
    input logic               meas_bad,
    input logic [FRAME_W-1:0] sreg,
    input logic [SPAN_W-1:0]  span
);

    localparam logic [SPAN_W-1:0] SPAN_TOP = '1;

    p_bad_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (meas_vld && meas_bad && state == ST_HUNT && !restart) |=> (sreg == '0));

    p_done_from_hunt_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(state) == ST_HUNT));

    p_ident_needs_rw_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ident_ok |-> rewritable);

    p_no_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(span) == SPAN_TOP && span != SPAN_TOP) |-> (span == '0));

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_hold_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLD && !restart) |=>
            ($stable(id_data) && $stable(id_check) && $stable(rewritable) &&
             $stable(ident_ok) && !done));

    p_restart_clears_r11: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (!done && id_data == '0 && state == ST_SYNC));

endmodule

bind lf_fsk_demod lf_fsk_demod_chk #(.SPAN_W(SPAN_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .restart    (restart),
    .done       (done),
    .id_data    (id_data),
    .id_check   (id_check),
    .rewritable (rewritable),
    .ident_ok   (ident_ok),
    .state      (state_q),
    .meas_vld   (meas_vld),
    .meas_bad   (meas_bad),
    .sreg       (sreg),
    .span       (span_now)
);

// File: tb/lf_fsk_demod_bench.sv
module lf_fsk_demod_bench;

    localparam int SMP_HZ = 500_000;
    localparam int B_LO   = (SMP_HZ * 16) / 123_200;
    localparam int B_HI   = (SMP_HZ * 16) / 134_200;
    localparam int B_TOL  = (B_LO - B_HI + 1) / 2;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        smp_en;
    logic        din;
    logic        restart;
    logic        done;
    logic [63:0] id_data;
    logic [15:0] id_check;
    logic        rewritable;
    logic        ident_ok;

    always #4 clk = ~clk;

    lf_fsk_demod #(.SAMPLE_HZ(SMP_HZ)) u_lf_fsk_demod (
        .clk        (clk),
        .rst_n      (rst_n),
        .smp_en     (smp_en),
        .din        (din),
        .restart    (restart),
        .done       (done),
        .id_data    (id_data),
        .id_check   (id_check),
        .rewritable (rewritable),
        .ident_ok   (ident_ok)
    );

    int n_chk = 0;
    int n_bad = 0;
    int done_cnt = 0;
    int drv_n = 0;
    int done_tick = -1;
    int edge_tick = 0;
    int span_of [128];
    logic [127:0] frm;

    task automatic expect_eq(input string req, input string what,
                             input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // One strobed sample, driven at the falling edge; records done pulses.
    task automatic drv(input logic d, input logic rs);
        @(negedge clk);
        if (done) begin
            done_cnt++;
            done_tick = drv_n;
        end
        din     = d;
        restart = rs;
        smp_en  = 1'b1;
        drv_n++;
    endtask

    // A cycle starts with its rising transition: ones first, then zeros.
    task automatic send_cycle(input int len);
        for (int i = 0; i < len; i++) drv(i < len / 2, 1'b0);
    endtask

    task automatic send_span(input int n);
        for (int k = 0; k < 16; k++) send_cycle(n / 16 + ((k < n % 16) ? 1 : 0));
    endtask

    task automatic send_frame();
        done_tick = -1;
        for (int i = 0; i < 6; i++) drv(1'b0, 1'b0);
        for (int b = 0; b < 128; b++) send_span(span_of[b]);
        edge_tick = drv_n;
        send_cycle(4);
        for (int i = 0; i < 4; i++) drv(1'b0, 1'b0);
    endtask

    task automatic do_restart();
        drv(1'b0, 1'b1);
        drv(1'b0, 1'b0);
    endtask

    function automatic int cls(input int n);
        if (n > B_LO - B_TOL && n < B_LO + B_TOL) return 1;
        if (n > B_HI - B_TOL && n < B_HI + B_TOL) return 0;
        return 2;
    endfunction

    function automatic logic [127:0] mk_frame(input logic [63:0] data, input logic [15:0] chk,
                                              input logic rw, input logic [14:0] ident,
                                              input logic top);
        logic [127:0] f;
        f          = '0;
        f[22:17]   = 6'h3F;
        f[87:24]   = data;
        f[103:88]  = chk;
        f[111]     = rw;
        f[126:112] = ident;
        f[127]     = top;
        return f;
    endfunction

    task automatic default_spans();
        for (int b = 0; b < 128; b++) span_of[b] = frm[b] ? B_LO : B_HI;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        logic [63:0] sv_data;
        logic [15:0] sv_chk;
        logic [9:0]  exp_sweep;
        int          d0;

        rst_n = 1'b0; din = 1'b0; smp_en = 1'b0; restart = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R12: reset state
        expect_eq("R12", "done", done, 0);
        expect_eq("R12", "id_data", id_data, 0);
        expect_eq("R12", "id_check", id_check, 0);
        expect_eq("R12", "rewritable", rewritable, 0);
        expect_eq("R12", "ident_ok", ident_ok, 0);

        // Frame A: span sweep through both windows on data bits 0..9 (R1, R2)
        frm = mk_frame(64'h5A3C_96E1_0F87_D24B, 16'h7E91, 1'b1, 15'h0, 1'b0);
        exp_sweep = '0;
        for (int k = 0; k < 10; k++) begin
            frm[24 + k]  = (cls(57 + k) == 1);
            exp_sweep[k] = (cls(57 + k) == 1);
        end
        frm[126:112] = frm[38:24];
        default_spans();
        for (int k = 0; k < 10; k++) span_of[24 + k] = 57 + k;
        d0 = done_cnt;
        send_frame();
        expect_eq("R5", "accept count", 64'(done_cnt - d0), 1);
        expect_eq("R9", "done latency", 64'(done_tick - edge_tick), 3);
        expect_eq("R2", "swept bits", {54'b0, id_data[9:0]}, {54'b0, exp_sweep});
        expect_eq("R1", "swept pattern", {54'b0, exp_sweep}, 64'h3E0);
        expect_eq("R4", "id_data", id_data, frm[87:24]);
        expect_eq("R6", "id_check", {48'b0, id_check}, {48'b0, frm[103:88]});
        expect_eq("R6", "rewritable", {63'b0, rewritable}, 1);
        expect_eq("R7", "ident_ok match", {63'b0, ident_ok}, 1);

        // R10: a further valid frame in HOLD is ignored
        sv_data = id_data;
        sv_chk  = id_check;
        frm = mk_frame(64'h1122_3344_5566_7788, 16'h7E00, 1'b0, 15'h0, 1'b0);
        default_spans();
        d0 = done_cnt;
        send_frame();
        expect_eq("R10", "no new done", 64'(done_cnt - d0), 0);
        expect_eq("R10", "id_data held", id_data, sv_data);
        expect_eq("R10", "id_check held", {48'b0, id_check}, {48'b0, sv_chk});

        // R11: restart clears outputs
        do_restart();
        expect_eq("R11", "id_data cleared", id_data, 0);
        expect_eq("R11", "rewritable cleared", {63'b0, rewritable}, 0);

        // Frame B: bit 127 differs from data bit 15, ident still matches (R7)
        frm = mk_frame(64'hC0DE_F00D_1234_8ABC, 16'h7E5A, 1'b1, 15'h0ABC, 1'b0);
        frm[127] = ~frm[39];
        default_spans();
        d0 = done_cnt;
        send_frame();
        expect_eq("R11", "accept after restart", 64'(done_cnt - d0), 1);
        expect_eq("R7", "ident_ok ignores bit 15", {63'b0, ident_ok}, 1);

        // Frame C: one ident bit differs (R7)
        do_restart();
        frm = mk_frame(64'h0F0F_AAAA_5555_3C3C, 16'h7E77, 1'b1, 15'h3C3C ^ 15'h0020, 1'b0);
        default_spans();
        send_frame();
        expect_eq("R7", "ident_ok mismatch", {63'b0, ident_ok}, 0);
        expect_eq("R6", "rewritable C", {63'b0, rewritable}, 1);

        // Frame D: read-only tag with equal ident field (R6, R7)
        do_restart();
        frm = mk_frame(64'h8000_0000_0000_1357, 16'h7EEE, 1'b0, 15'h1357, 1'b1);
        default_spans();
        d0 = done_cnt;
        send_frame();
        expect_eq("R6", "read-only done", 64'(done_cnt - d0), 1);
        expect_eq("R6", "rewritable D", {63'b0, rewritable}, 0);
        expect_eq("R7", "ident_ok read-only", {63'b0, ident_ok}, 0);

        // Frame E: closing byte 7D differs from start byte 7E (R5)
        do_restart();
        frm = mk_frame(64'h2468_ACE0_1357_9BDF, 16'h7D55, 1'b0, 15'h0, 1'b0);
        default_spans();
        d0 = done_cnt;
        send_frame();
        expect_eq("R5", "end byte mismatch", 64'(done_cnt - d0), 0);

        // Frames F, G: span just outside each window mid-frame (R3)
        do_restart();
        frm = mk_frame(64'h7777_1111_2222_3333, 16'h7E10, 1'b0, 15'h0, 1'b0);
        default_spans();
        span_of[60] = B_HI - B_TOL;
        d0 = done_cnt;
        send_frame();
        expect_eq("R3", "low reject", 64'(done_cnt - d0), 0);

        do_restart();
        default_spans();
        span_of[60] = B_LO + B_TOL;
        d0 = done_cnt;
        send_frame();
        expect_eq("R3", "high reject", 64'(done_cnt - d0), 0);

        // Frame H: gap of 128+62 samples would wrap to a valid 1 (R8)
        do_restart();
        frm = mk_frame(64'h7777_1111_2222_3333, 16'h7E10, 1'b0, 15'h0, 1'b0);
        frm[70] = 1'b1;
        default_spans();
        span_of[70] = 190;
        d0 = done_cnt;
        send_frame();
        expect_eq("R8", "saturated gap rejected", 64'(done_cnt - d0), 0);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule